// File: doc/BRIEF.md
# Stack Cache Spill/Fill Dribbler

This block runs beside a 64-entry stack cache and keeps the number of resident stack words inside a safe window while the pipeline keeps issuing. It compares the stack-top pointer with a bottom pointer that it owns. When too many words are resident, it moves the deepest word out to data memory. When too few are resident, it brings the word just below the bottom back into the cache. It moves one word at a time over a request/ready memory port and a cache read/write port.

The pipeline may rely on the four topmost stack words being resident and on two free slots above the top. Whenever that is not assured and dribbling is enabled, the block raises a hold until its transfers restore the window. Software supplies an enable bit and a fill threshold. When the enable is off, the block never holds the pipeline and starts no transfers. It then gives no residency guarantee, and software must manage the cache itself. Software sets the bottom pointer through a load strobe, and should do so only while dribbling is off and no transfer is in flight.

Top module: `stk_dribbler`

## Requirements
- R1: Occupancy is (top_ptr - bottom + 1) taken modulo 64. When enabled, `hold_o` is 1 exactly when occupancy is below 4 or above 62.
- R2: With `dre_en_i` = 0, `hold_o` stays 0, no new transfer starts, and `bot_o` is unchanged (no `mem_req_o`).
- R3: `cfg_err_o` is 1 exactly when `dre_en_i` = 1 and `fill_mark_i` = 0.
- R4: When occupancy exceeds SPILL_MARK (default 48), the cache entry at index `bot_o[5:0]` is written to memory address `bot_o` (`mem_we_o` = 1). After `mem_rdy_i`, the bottom pointer moves up by one. Enabled dribbling settles at an occupancy of SPILL_MARK.
- R5: The effective fill threshold is `fill_mark_i` clamped to the range [4, 62]. When occupancy is below it, memory address `bot_o`-1 is read (`mem_we_o` = 0) and written into cache index (`bot_o`-1)[5:0], and the bottom pointer moves down by one. Dribbling settles at the threshold.
- R6: Only one transfer is in flight at a time. A request keeps its address and direction stable until `mem_rdy_i`. Without a load, the bottom pointer changes by at most one word per cycle.
- R7: If spill and fill conditions hold together, the spill is started first.
- R8: `hold_o` responds in the same cycle that `top_ptr_i` changes, with no register in between.
- R9: A load strobe `bot_ld_i` sets the bottom pointer to `bot_ld_val_i` in the next cycle, and no transfer starts in the cycle of the load.
- R10: After reset, the bottom pointer is 0 and no memory request or cache write is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dre_en_i | input | 1 | Dribbling enable from the status register |
| fill_mark_i | input | 6 | Programmed fill threshold |
| top_ptr_i | input | AW | Word address of the top stack word |
| bot_ld_i | input | 1 | Load strobe for the bottom pointer |
| bot_ld_val_i | input | AW | Value loaded into the bottom pointer |
| bot_o | output | AW | Word address of the deepest resident word |
| hold_o | output | 1 | Pipeline hold |
| cfg_err_o | output | 1 | Illegal fill threshold while enabled |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Spill data |
| mem_rdy_i | input | 1 | Memory accepts/completes the request |
| mem_rdata_i | input | DW | Fill data, valid with `mem_rdy_i` |
| cache_re_o | output | 1 | Cache read strobe for a spill |
| cache_ridx_o | output | 6 | Cache read index |
| cache_rdata_i | input | DW | Cache read data (same cycle) |
| cache_we_o | output | 1 | Cache write strobe for a fill |
| cache_widx_o | output | 6 | Cache write index |
| cache_wdata_o | output | DW | Cache write data |

## Verification
The assertions check the following on every cycle: a hold never appears while dribbling is off, a pending request keeps its address and direction, the bottom pointer only steps by one word or takes a loaded value, an idle controller stays idle while disabled, and a spill wins when both conditions hold. The bench's scenarios show the rest. They sweep every occupancy for the hold window, cover several fill thresholds and memory latencies, and check the occupancy each run settles to. They compare the words that reached memory or the cache against patterns the bench computed, and confirm the same-cycle response to a jump of the stack-top pointer.

// File: rtl/stk_dribbler_pkg.sv
package stk_dribbler_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPILL_RD,
    ST_SPILL_WR,
    ST_FILL_REQ,
    ST_FILL_WR
  } drib_state_e;
endpackage

// File: rtl/stk_occ_mon.sv
module stk_occ_mon #(
  parameter int AW         = 12,
  parameter int IDX_W      = 6,
  parameter int MIN_OCC    = 4,
  parameter int MAX_OCC    = 62,
  parameter int SPILL_MARK = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IDX_W-1:0] fill_mark_i,
  input  logic [AW-1:0]    top_ptr_i,
  input  logic [AW-1:0]    bot_ptr_i,
  output logic             hold_o,
  output logic             spill_need_o,
  output logic             fill_need_o,
  output logic             cfg_err_o
);
  localparam logic [IDX_W-1:0] MinOcc   = IDX_W'(MIN_OCC);
  localparam logic [IDX_W-1:0] MaxOcc   = IDX_W'(MAX_OCC);
  localparam logic [IDX_W-1:0] SpillLim = IDX_W'(SPILL_MARK);

  logic [AW-1:0]    span;
  logic [IDX_W-1:0] occ;
  logic [IDX_W-1:0] fill_eff;

  assign span = top_ptr_i - bot_ptr_i + AW'(1);
  assign occ  = span[IDX_W-1:0];

  // clamp the programmed threshold so the guarantee window is always reachable
  always_comb begin
    if (fill_mark_i < MinOcc)      fill_eff = MinOcc;
    else if (fill_mark_i > MaxOcc) fill_eff = MaxOcc;
    else                           fill_eff = fill_mark_i;
  end

  assign hold_o       = en_i && ((occ < MinOcc) || (occ > MaxOcc));
  assign spill_need_o = occ > SpillLim;
  assign fill_need_o  = occ < fill_eff;
  assign cfg_err_o    = en_i && (fill_mark_i == '0);

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !hold_o); // R2

endmodule

// File: rtl/stk_xfer_fsm.sv
module stk_xfer_fsm
  import stk_dribbler_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             spill_need_i,
  input  logic             fill_need_i,
  input  logic             bot_ld_i,
  input  logic [AW-1:0]    bot_ld_val_i,
  output logic [AW-1:0]    bot_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_rdy_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             cache_re_o,
  output logic [IDX_W-1:0] cache_ridx_o,
  input  logic [DW-1:0]    cache_rdata_i,
  output logic             cache_we_o,
  output logic [IDX_W-1:0] cache_widx_o,
  output logic [DW-1:0]    cache_wdata_o
);
  drib_state_e   state_q, state_d;
  logic [AW-1:0] bot_q, bot_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          start_ok;

  assign start_ok = en_i && !bot_ld_i;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    buf_d   = buf_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok && spill_need_i) begin
          state_d = ST_SPILL_RD;
          addr_d  = bot_q;
        end else if (start_ok && fill_need_i) begin
          state_d = ST_FILL_REQ;
          addr_d  = bot_q - AW'(1);
        end
      end
      ST_SPILL_RD: begin
        state_d = ST_SPILL_WR;
        buf_d   = cache_rdata_i;
      end
      ST_SPILL_WR: if (mem_rdy_i) state_d = ST_IDLE;
      ST_FILL_REQ: begin
        if (mem_rdy_i) begin
          state_d = ST_FILL_WR;
          buf_d   = mem_rdata_i;
        end
      end
      ST_FILL_WR: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    bot_d = bot_q;
    if (bot_ld_i)                                bot_d = bot_ld_val_i;
    else if (state_q == ST_SPILL_WR && mem_rdy_i) bot_d = bot_q + AW'(1);
    else if (state_q == ST_FILL_WR)              bot_d = bot_q - AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bot_q   <= '0;
      addr_q  <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      bot_q   <= bot_d;
      addr_q  <= addr_d;
      buf_q   <= buf_d;
    end
  end

  assign bot_o         = bot_q;
  assign mem_req_o     = (state_q == ST_SPILL_WR) || (state_q == ST_FILL_REQ);
  assign mem_we_o      = (state_q == ST_SPILL_WR);
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = buf_q;
  assign cache_re_o    = (state_q == ST_SPILL_RD);
  assign cache_ridx_o  = addr_q[IDX_W-1:0];
  assign cache_we_o    = (state_q == ST_FILL_WR);
  assign cache_widx_o  = addr_q[IDX_W-1:0];
  assign cache_wdata_o = buf_q;

  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R6

  AST_BOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bot_ld_i |=> ((bot_o == $past(bot_o)) || (bot_o == $past(bot_o) + AW'(1)) ||
                   (bot_o == $past(bot_o) - AW'(1)))); // R6

  AST_BOT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bot_ld_i |=> (bot_o == $past(bot_ld_val_i))); // R9

  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !en_i) |=> (state_q == ST_IDLE)); // R2

  AST_SPILL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_ok && spill_need_i) |=> (state_q == ST_SPILL_RD)); // R7

  AST_ONE_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && (cache_re_o || cache_we_o))); // R6

endmodule

// File: rtl/stk_dribbler.sv
module stk_dribbler #(
  parameter int AW         = 12,
  parameter int DW         = 16,
  parameter int IDX_W      = 6,
  parameter int TOP_KEEP   = 4,
  parameter int FREE_KEEP  = 2,
  parameter int SPILL_MARK = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dre_en_i,
  input  logic [IDX_W-1:0] fill_mark_i,
  input  logic [AW-1:0]    top_ptr_i,
  input  logic             bot_ld_i,
  input  logic [AW-1:0]    bot_ld_val_i,
  output logic [AW-1:0]    bot_o,
  output logic             hold_o,
  output logic             cfg_err_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_rdy_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             cache_re_o,
  output logic [IDX_W-1:0] cache_ridx_o,
  input  logic [DW-1:0]    cache_rdata_i,
  output logic             cache_we_o,
  output logic [IDX_W-1:0] cache_widx_o,
  output logic [DW-1:0]    cache_wdata_o
);
  localparam int Entries = 1 << IDX_W;
  localparam int MinOcc  = TOP_KEEP;
  localparam int MaxOcc  = Entries - FREE_KEEP;

  logic spill_need, fill_need;

  stk_occ_mon #(
    .AW(AW), .IDX_W(IDX_W), .MIN_OCC(MinOcc), .MAX_OCC(MaxOcc), .SPILL_MARK(SPILL_MARK)
  ) u_occ (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (dre_en_i),
    .fill_mark_i  (fill_mark_i),
    .top_ptr_i    (top_ptr_i),
    .bot_ptr_i    (bot_o),
    .hold_o       (hold_o),
    .spill_need_o (spill_need),
    .fill_need_o  (fill_need),
    .cfg_err_o    (cfg_err_o)
  );

  stk_xfer_fsm #(
    .AW(AW), .DW(DW), .IDX_W(IDX_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (dre_en_i),
    .spill_need_i  (spill_need),
    .fill_need_i   (fill_need),
    .bot_ld_i      (bot_ld_i),
    .bot_ld_val_i  (bot_ld_val_i),
    .bot_o         (bot_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_rdy_i     (mem_rdy_i),
    .mem_rdata_i   (mem_rdata_i),
    .cache_re_o    (cache_re_o),
    .cache_ridx_o  (cache_ridx_o),
    .cache_rdata_i (cache_rdata_i),
    .cache_we_o    (cache_we_o),
    .cache_widx_o  (cache_widx_o),
    .cache_wdata_o (cache_wdata_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!mem_req_o && !cache_we_o)); // R10

endmodule

// File: tb/stk_dribbler_tb.sv
`timescale 1ns/1ps
module stk_dribbler_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int BASE = 100;
  localparam int WD_LIMIT = 150000;

  logic clk = 0;
  logic rst_n = 0;
  logic en = 0;
  logic [5:0] fill_mark = 6'd8;
  logic [AW-1:0] top_ptr = '0;
  logic bot_ld = 0;
  logic [AW-1:0] bot_ld_val = '0;
  logic [AW-1:0] bot;
  logic hold, cfg_err, mem_req, mem_we, mem_rdy, cache_re, cache_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, cache_rdata, cache_wdata;
  logic [5:0] cache_ridx, cache_widx;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] cache [64];
  int lat = 0;
  int wait_cnt = 0;
  logic init_go = 0;
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int req_seen = 0;

  always #2.5 clk = ~clk;

  stk_dribbler u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dre_en_i(en), .fill_mark_i(fill_mark),
    .top_ptr_i(top_ptr), .bot_ld_i(bot_ld), .bot_ld_val_i(bot_ld_val),
    .bot_o(bot), .hold_o(hold), .cfg_err_o(cfg_err),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdy_i(mem_rdy), .mem_rdata_i(mem_rdata),
    .cache_re_o(cache_re), .cache_ridx_o(cache_ridx), .cache_rdata_i(cache_rdata),
    .cache_we_o(cache_we), .cache_widx_o(cache_widx), .cache_wdata_o(cache_wdata)
  );

  function automatic logic [DW-1:0] mem_pat(int a);
    return DW'((a * 37 + 16'h1234) & 16'hffff);
  endfunction
  function automatic logic [DW-1:0] cache_pat(int i);
    return DW'(16'hc000 | (i * 5));
  endfunction

  assign mem_rdy     = mem_req && (wait_cnt == lat);
  assign mem_rdata   = mem[mem_addr[7:0]];
  assign cache_rdata = cache[cache_ridx];

  // memory and cache models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) req_seen <= req_seen + 1;
    if (mem_req && !mem_rdy) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (init_go) begin
      for (int i = 0; i < 256; i++) mem[i] <= mem_pat(i);
      for (int i = 0; i < 64; i++) cache[i] <= cache_pat(i);
    end else begin
      if (mem_req && mem_rdy && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (cache_we) cache[cache_widx] <= cache_wdata;
    end
  end

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_bot(input int b, input int k);
    @(negedge clk);
    bot_ld = 1;
    bot_ld_val = AW'(b);
    top_ptr = AW'(b + k - 1);
    @(negedge clk);
    bot_ld = 0;
  endtask

  task automatic init_models;
    @(negedge clk);
    init_go = 1;
    @(negedge clk);
    init_go = 0;
  endtask

  task automatic settle_run(input int k, input int m, input int l);
    int eff, n_sp, n_fl, exp_bot, bad;
    en = 0;
    cycles(20);
    lat = l;
    fill_mark = 6'(m);
    init_models();
    load_bot(BASE, k);
    en = 1;
    cycles(64 * (l + 4));
    en = 0;
    cycles(2);
    eff = (m < 4) ? 4 : ((m > 62) ? 62 : m);
    n_sp = (k > 48) ? k - 48 : 0;
    n_fl = (k < eff) ? eff - k : 0;
    exp_bot = BASE + n_sp - n_fl;
    if (n_sp > 0) chk(int'(bot) == exp_bot, "R4 spill settle bottom", int'(bot), exp_bot);
    else if (n_fl > 0) chk(int'(bot) == exp_bot, "R5 fill settle bottom", int'(bot), exp_bot);
    else chk(int'(bot) == exp_bot, "R2 in-window no move", int'(bot), exp_bot);
    bad = 0;
    for (int j = 0; j < n_sp; j++)
      if (mem[(BASE + j) & 255] != cache_pat((BASE + j) & 63)) bad++;
    if (n_sp > 0) chk(bad == 0, "R4 spilled words in memory", bad, 0);
    bad = 0;
    for (int j = 1; j <= n_fl; j++)
      if (cache[(BASE - j) & 63] != mem_pat(BASE - j)) bad++;
    if (n_fl > 0) chk(bad == 0, "R5 filled words in cache", bad, 0);
  endtask

  initial begin
    int ks[13] = '{0, 2, 3, 4, 5, 10, 30, 47, 48, 49, 55, 62, 63};
    int ms[3] = '{1, 8, 20};
    int r0;
    // R10 reset state
    cycles(3);
    chk(bot == '0, "R10 reset bottom", int'(bot), 0);
    chk(!mem_req && !cache_we, "R10 reset quiet", int'(mem_req), 0);
    rst_n = 1;
    cycles(2);
    chk(bot == '0 && !mem_req, "R10 after release", int'(bot), 0);

    // R3 threshold error flag
    en = 1; fill_mark = 0; #1;
    chk(cfg_err == 1'b1, "R3 zero mark enabled", int'(cfg_err), 1);
    en = 0; #1;
    chk(cfg_err == 1'b0, "R3 zero mark disabled", int'(cfg_err), 0);
    en = 1; fill_mark = 6'd5; #1;
    chk(cfg_err == 1'b0, "R3 legal mark", int'(cfg_err), 0);
    en = 0;

    // R1 / R2 hold sweep over all occupancies
    init_models();
    for (int e = 0; e < 2; e++) begin
      for (int k = 0; k < 64; k++) begin
        en = (e == 1);
        fill_mark = 6'd8;
        load_bot(BASE, k);
        if (e == 1)
          chk(hold == ((k < 4) || (k > 62)), "R1 hold window", int'(hold), int'((k < 4) || (k > 62)));
        else
          chk(hold == 1'b0, "R2 hold off when disabled", int'(hold), 0);
      end
    end
    en = 0;
    cycles(30);

    // R2 no transfers while disabled, even far outside the window
    load_bot(BASE, 60);
    r0 = req_seen;
    cycles(200);
    chk(req_seen == r0, "R2 no request disabled", req_seen - r0, 0);
    chk(int'(bot) == BASE, "R2 bottom unchanged", int'(bot), BASE);
    load_bot(BASE, 1);
    cycles(100);
    chk(req_seen == r0 && int'(bot) == BASE, "R2 no fill disabled", req_seen - r0, 0);

    // R9 load takes effect next cycle
    @(negedge clk);
    bot_ld = 1; bot_ld_val = 12'd777;
    @(negedge clk);
    bot_ld = 0;
    chk(int'(bot) == 777, "R9 load value", int'(bot), 777);

    // R4 / R5 settle sweeps over occupancy, threshold and latency
    for (int li = 0; li < 2; li++)
      for (int mi = 0; mi < 3; mi++)
        for (int ki = 0; ki < 13; ki++)
          settle_run(ks[ki], ms[mi], (li == 0) ? 0 : 3);

    // R7 spill wins over fill (mark 60, occupancy 50)
    cycles(20);
    lat = 1;
    fill_mark = 6'd60;
    init_models();
    load_bot(BASE, 50);
    en = 1;
    for (int i = 0; i < 20 && !mem_req; i++) @(negedge clk);
    chk(mem_req && mem_we, "R7 spill first", int'(mem_we), 1);
    chk(int'(mem_addr) == BASE, "R7 spill address", int'(mem_addr), BASE);
    en = 0;
    cycles(20);

    // R8 same-cycle hold on a stack-top jump, then R1 recovery
    fill_mark = 6'd8;
    load_bot(BASE, 30);
    en = 1;
    cycles(10);
    chk(hold == 1'b0, "R8 steady no hold", int'(hold), 0);
    top_ptr = AW'(BASE + 63 - 1);
    #1;
    chk(hold == 1'b1, "R8 hold same cycle", int'(hold), 1);
    cycles(200);
    chk(hold == 1'b0, "R1 hold released", int'(hold), 0);
    chk(int'(bot) == BASE + 15, "R4 spilled to mark", int'(bot), BASE + 15);
    en = 0;
    cycles(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule